// File: doc/BRIEF.md
# Hypercube Node Router with Dimension-Ordered Cut-Through

This block is the switching element of one node in a binary hypercube. The node has one serial link per dimension and one local port. Each input carries one bit per cycle. A message has a fixed-length routing header followed by a payload. The last payload bit carries an end flag. The node's own address is a parameter. Each message leaves on the link of the lowest dimension in which the destination differs from that address. If the destination equals the node's own address, the message goes to the local delivery port instead.

Every input has its own bit buffer that is always open, so arriving bits are never refused. An input starts forwarding as soon as the whole header has come in, without waiting for the end of the message. It asks for the output that the header selects, and it keeps that output until the end-flagged bit has left. Messages on different outputs move at the same time. When several inputs want the same free output, an arbiter picks one, and the others wait with their bits still buffered.

Top module: `hc_router`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no output link or delivery port shows a valid bit.
- R2: The header is HDR_BITS (default 36) bits long. It arrives least-significant bit first, and the destination address sits in its low N_DIM bits. A message whose destination differs from the node address is sent on the link of the lowest differing dimension (bit d of destination XOR node address selects link d).
- R3: A message whose destination equals the node address is sent out on the local delivery port and on no link.
- R4: An output reproduces the whole message unchanged. The header bits come first in arrival order, then the payload bits in order. The end flag is set on the final payload bit only.
- R5: Forwarding starts once the header is complete. The first bit on the output appears before the last bit of a long message has reached the input.
- R6: An output that has been granted stays with its input until that input's end-flagged bit has left. Bits of two messages never mix on one output.
- R7: Contention is settled round-robin. A pointer starts at input 0 after reset and, after each grant, moves to the input just past the winner. Among the simultaneous requesters, the first one at or after the pointer wins. Link inputs are numbered 0..N_DIM-1 and the injection input is numbered N_DIM. The ARB_RR=0 build grants the lowest-numbered requester instead.
- R8: Messages that are routed to different outputs are forwarded in the same cycles.
- R9: Header bits above the address field have no effect on the choice of output, and they are forwarded unchanged.
- R10: Inputs accept every arriving bit, including bits that arrive while the input waits for an output. A losing input's message is delivered intact after the winner's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_in_vld | input | N_DIM | Per-dimension input link: bit valid |
| lnk_in_bit | input | N_DIM | Per-dimension input link: data bit |
| lnk_in_end | input | N_DIM | Per-dimension input link: last bit of message |
| inj_vld | input | 1 | Local injection: bit valid |
| inj_bit | input | 1 | Local injection: data bit |
| inj_end | input | 1 | Local injection: last bit of message |
| lnk_out_vld | output | N_DIM | Per-dimension output link: bit valid |
| lnk_out_bit | output | N_DIM | Per-dimension output link: data bit |
| lnk_out_end | output | N_DIM | Per-dimension output link: last bit of message |
| dlv_vld | output | 1 | Local delivery: bit valid |
| dlv_bit | output | 1 | Local delivery: data bit |
| dlv_end | output | 1 | Local delivery: last bit of message |

## Verification
The assertions check the ownership rules on every cycle. An output never has more than one granted input. It never takes a new grant while held, and its owner does not change until the release. A grant only answers a request, an end flag only appears with a valid bit, and no input buffer is written while full. Several behaviours can only be shown by the bench scenarios: the choice of output from the address, the exact bit order and end flag of forwarded messages, the round-robin order under contention, cut-through timing and concurrency across outputs. Each scenario compares every output bit against a queue of expected messages.

// File: rtl/hc_router_pkg.sv
package hc_router_pkg;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,   // collecting header bits from the buffer
      ST_REQ  = 2'd1,   // header complete, requesting output
      ST_HOUT = 2'd2,   // replaying the stored header onto the output
      ST_BODY = 2'd3    // streaming payload until the end flag
   } hc_in_state_t;

   typedef struct packed {
      logic fin;
      logic dat;
   } hc_bit_t;

endpackage

// File: rtl/hc_bit_fifo.sv
module hc_bit_fifo #(
   parameter int DEPTH = 128
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  hc_router_pkg::hc_bit_t  wdat,
   input  logic                    rd,
   output hc_router_pkg::hc_bit_t  head,
   output logic                    nempty,
   output logic                    full
);
   import hc_router_pkg::*;

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hc_bit_fifo: DEPTH must be a power of two and at least 2");
   end

   hc_bit_t        mem [DEPTH];
   logic [AW-1:0]  wp, rp;
   logic [AW:0]    cnt;
   logic           do_rd;

   assign do_rd  = rd && (cnt != '0);
   assign head   = mem[rp];
   assign nempty = (cnt != '0);
   assign full   = (cnt == (AW+1)'(DEPTH));

   always_ff @(posedge clk) begin
      if (wr) mem[wp] <= wdat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr)    wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         case ({wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/hc_in_unit.sv
module hc_in_unit #(
   parameter int N_DIM     = 3,
   parameter int NODE_ADDR = 0,
   parameter int HDR_BITS  = 36,
   parameter int DEPTH     = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              in_bit,
   input  logic              in_end,
   input  logic              gnt,
   output logic [N_DIM:0]    req,
   output logic              snd_vld,
   output logic              snd_bit,
   output logic              snd_end,
   output logic              buf_full
);
   import hc_router_pkg::*;

   localparam int NP = N_DIM + 1;
   localparam int CW = $clog2(HDR_BITS);
   localparam logic [N_DIM-1:0] OWN = N_DIM'(NODE_ADDR);
   localparam logic [CW-1:0] LAST = CW'(HDR_BITS - 1);

   hc_in_state_t        st;
   logic [HDR_BITS-1:0] shreg;
   logic [CW-1:0]       cnt;
   hc_bit_t             head;
   logic                nempty;
   logic                pop;
   logic [N_DIM-1:0]    diff;
   int                  port;

   hc_bit_fifo #(.DEPTH(DEPTH)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (in_vld),
      .wdat   ('{fin: in_end, dat: in_bit}),
      .rd     (pop),
      .head   (head),
      .nempty (nempty),
      .full   (buf_full)
   );

   // lowest differing dimension, or the local port when equal
   always_comb begin
      diff = shreg[N_DIM-1:0] ^ OWN;
      port = N_DIM;
      for (int d = N_DIM - 1; d >= 0; d--) begin
         if (diff[d]) port = d;
      end
      req = (st == ST_REQ) ? (NP'(1) << port) : '0;
   end

   assign pop     = nempty && (st == ST_HDR || st == ST_BODY);
   assign snd_vld = (st == ST_HOUT) || (st == ST_BODY && nempty);
   assign snd_bit = (st == ST_HOUT) ? shreg[0] : head.dat;
   assign snd_end = (st == ST_BODY) && nempty && head.fin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_HDR;
         shreg <= '0;
         cnt   <= '0;
      end else begin
         case (st)
            ST_HDR: if (nempty) begin
               shreg <= {head.dat, shreg[HDR_BITS-1:1]};
               if (cnt == LAST) begin
                  cnt <= '0;
                  st  <= ST_REQ;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REQ: if (gnt) st <= ST_HOUT;
            ST_HOUT: begin
               shreg <= {shreg[0], shreg[HDR_BITS-1:1]};
               if (cnt == LAST) begin
                  cnt <= '0;
                  st  <= ST_BODY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BODY: if (nempty && head.fin) st <= ST_HDR;
            default: st <= ST_HDR;
         endcase
      end
   end
endmodule

// File: rtl/hc_out_arb.sv
module hc_out_arb #(
   parameter int NP     = 4,
   parameter bit ARB_RR = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NP-1:0]           req,
   input  logic                    rel,
   output logic [NP-1:0]           gnt,
   output logic                    busy,
   output logic [$clog2(NP)-1:0]   owner
);
   localparam int IW = $clog2(NP);

   logic [IW-1:0] win;
   logic          found;

   if (ARB_RR) begin : g_rr
      logic [IW-1:0] ptr;

      always_comb begin
         win   = '0;
         found = 1'b0;
         for (int k = 0; k < NP; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NP) idx = idx - NP;
            if (!found && req[idx]) begin
               found = 1'b1;
               win   = IW'(idx);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) ptr <= '0;
         else if (found && !busy)
            ptr <= (int'(win) == NP - 1) ? '0 : win + 1'b1;
      end
   end else begin : g_fixed
      always_comb begin
         win   = '0;
         found = 1'b0;
         for (int k = NP - 1; k >= 0; k--) begin
            if (req[k]) begin
               found = 1'b1;
               win   = IW'(k);
            end
         end
      end
   end

   always_comb begin
      gnt = '0;
      if (found && !busy) gnt[win] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
      end else if (busy) begin
         if (rel) busy <= 1'b0;
      end else if (found) begin
         busy  <= 1'b1;
         owner <= win;
      end
   end
endmodule

// File: rtl/hc_router.sv
module hc_router #(
   parameter int N_DIM     = 3,
   parameter int NODE_ADDR = 5,
   parameter int HDR_BITS  = 36,
   parameter int DEPTH     = 128,
   parameter bit ARB_RR    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DIM-1:0]  lnk_in_vld,
   input  logic [N_DIM-1:0]  lnk_in_bit,
   input  logic [N_DIM-1:0]  lnk_in_end,
   input  logic              inj_vld,
   input  logic              inj_bit,
   input  logic              inj_end,
   output logic [N_DIM-1:0]  lnk_out_vld,
   output logic [N_DIM-1:0]  lnk_out_bit,
   output logic [N_DIM-1:0]  lnk_out_end,
   output logic              dlv_vld,
   output logic              dlv_bit,
   output logic              dlv_end
);
   localparam int NP = N_DIM + 1;
   localparam int IW = $clog2(NP);

   if (N_DIM < 1 || N_DIM > 8) begin : g_bad_dim
      $error("hc_router: N_DIM must lie in 1..8");
   end
   if (HDR_BITS <= N_DIM) begin : g_bad_hdr
      $error("hc_router: header must be wider than the address");
   end
   if (NODE_ADDR < 0 || NODE_ADDR >= (1 << N_DIM)) begin : g_bad_addr
      $error("hc_router: NODE_ADDR out of range");
   end
   if (DEPTH < HDR_BITS) begin : g_bad_buf
      $error("hc_router: DEPTH must hold at least one header");
   end

   logic [NP-1:0]          in_vld, in_bit, in_end;
   logic [NP-1:0][NP-1:0]  req_m;      // [input][output]
   logic [NP-1:0][NP-1:0]  req_col;    // [output][input]
   logic [NP-1:0][NP-1:0]  gnt_m;      // [output][input]
   logic [NP-1:0]          gnt_in;
   logic [NP-1:0]          snd_vld, snd_bit, snd_end;
   logic [NP-1:0]          buf_full;
   logic [NP-1:0]          busy, rel;
   logic [NP-1:0][IW-1:0]  owner;
   logic [NP-1:0]          o_vld, o_bit, o_end;

   assign in_vld = {inj_vld, lnk_in_vld};
   assign in_bit = {inj_bit, lnk_in_bit};
   assign in_end = {inj_end, lnk_in_end};

   always_comb begin
      for (int o = 0; o < NP; o++)
         for (int i = 0; i < NP; i++)
            req_col[o][i] = req_m[i][o];
      for (int i = 0; i < NP; i++) begin
         gnt_in[i] = 1'b0;
         for (int o = 0; o < NP; o++)
            gnt_in[i] = gnt_in[i] | gnt_m[o][i];
      end
   end

   for (genvar i = 0; i < NP; i++) begin : g_in
      hc_in_unit #(
         .N_DIM(N_DIM), .NODE_ADDR(NODE_ADDR),
         .HDR_BITS(HDR_BITS), .DEPTH(DEPTH)
      ) u_in (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_vld   (in_vld[i]),
         .in_bit   (in_bit[i]),
         .in_end   (in_end[i]),
         .gnt      (gnt_in[i]),
         .req      (req_m[i]),
         .snd_vld  (snd_vld[i]),
         .snd_bit  (snd_bit[i]),
         .snd_end  (snd_end[i]),
         .buf_full (buf_full[i])
      );
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      assign rel[o] = busy[o] && snd_vld[owner[o]] && snd_end[owner[o]];

      hc_out_arb #(.NP(NP), .ARB_RR(ARB_RR)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (req_col[o]),
         .rel   (rel[o]),
         .gnt   (gnt_m[o]),
         .busy  (busy[o]),
         .owner (owner[o])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            o_vld[o] <= 1'b0;
            o_bit[o] <= 1'b0;
            o_end[o] <= 1'b0;
         end else begin
            o_vld[o] <= busy[o] && snd_vld[owner[o]];
            o_bit[o] <= busy[o] && snd_bit[owner[o]];
            o_end[o] <= busy[o] && snd_vld[owner[o]] && snd_end[owner[o]];
         end
      end
   end

   assign lnk_out_vld = o_vld[N_DIM-1:0];
   assign lnk_out_bit = o_bit[N_DIM-1:0];
   assign lnk_out_end = o_end[N_DIM-1:0];
   assign dlv_vld     = o_vld[N_DIM];
   assign dlv_bit     = o_bit[N_DIM];
   assign dlv_end     = o_end[N_DIM];
endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk #(
   parameter int NP = 4,
   parameter int IW = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NP-1:0]          out_vld,
   input logic [NP-1:0]          out_end,
   input logic [NP-1:0][NP-1:0]  req_m,
   input logic [NP-1:0][NP-1:0]  gnt_m,
   input logic [NP-1:0]          busy,
   input logic [NP-1:0]          rel,
   input logic [NP-1:0][IW-1:0]  owner,
   input logic [NP-1:0]          in_vld,
   input logic [NP-1:0]          buf_full
);
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> out_vld == '0);

   for (genvar o = 0; o < NP; o++) begin : g_o
      a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gnt_m[o]));
      a_r6_no_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
         busy[o] |-> gnt_m[o] == '0);
      a_r6_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
         busy[o] && !rel[o] |=> busy[o] && $stable(owner[o]));
      a_r4_end_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
         out_end[o] |-> out_vld[o]);
      for (genvar i = 0; i < NP; i++) begin : g_i
         a_r7_grant_answers_req: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_m[o][i] |-> req_m[i][o]);
      end
   end

   for (genvar i = 0; i < NP; i++) begin : g_in
      a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld[i] |-> !buf_full[i]);
      a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(req_m[i]));
   end
endmodule

bind hc_router hc_router_chk #(.NP(NP), .IW(IW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_vld  (o_vld),
   .out_end  (o_end),
   .req_m    (req_m),
   .gnt_m    (gnt_m),
   .busy     (busy),
   .rel      (rel),
   .owner    (owner),
   .in_vld   (in_vld),
   .buf_full (buf_full)
);

// File: tb/hc_router_tb_top.sv
module hc_router_tb_top;
   localparam int N_DIM = 3;
   localparam int NODE  = 5;
   localparam int HB    = 36;
   localparam int NP    = N_DIM + 1;
   localparam int LOC   = N_DIM;   // delivery output / injection input index

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NP-1:0] drv_vld = '0, drv_bit = '0, drv_end = '0;
   logic [N_DIM-1:0] lo_vld, lo_bit, lo_end;
   logic d_vld, d_bit, d_end;
   logic [NP-1:0] ov, ob, oe;

   hc_router #(.N_DIM(N_DIM), .NODE_ADDR(NODE), .HDR_BITS(HB)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lnk_in_vld(drv_vld[N_DIM-1:0]), .lnk_in_bit(drv_bit[N_DIM-1:0]),
      .lnk_in_end(drv_end[N_DIM-1:0]),
      .inj_vld(drv_vld[LOC]), .inj_bit(drv_bit[LOC]), .inj_end(drv_end[LOC]),
      .lnk_out_vld(lo_vld), .lnk_out_bit(lo_bit), .lnk_out_end(lo_end),
      .dlv_vld(d_vld), .dlv_bit(d_bit), .dlv_end(d_end)
   );

   assign ov = {d_vld, lo_vld};
   assign ob = {d_bit, lo_bit};
   assign oe = {d_end, lo_end};

   int checks = 0, fails = 0, cyc = 0;
   string cur_req = "R4";
   logic [1:0] exp_q [NP][$];
   int first_cyc [NP];
   int last_in_cyc [NP];
   bit both_seen = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic pbit(logic [31:0] seed, int k);
      return seed[k % 32] ^ k[5];
   endfunction

   // expected output from the requirements: lowest differing dimension
   function automatic int route(logic [HB-1:0] h);
      logic [N_DIM-1:0] d;
      d = h[N_DIM-1:0] ^ N_DIM'(NODE);
      for (int k = 0; k < N_DIM; k++) if (d[k]) return k;
      return LOC;
   endfunction

   task automatic expect_msg(logic [HB-1:0] h, int len, logic [31:0] seed);
      int o;
      o = route(h);
      for (int k = 0; k < HB; k++) exp_q[o].push_back({1'b0, h[k]});
      for (int k = 0; k < len; k++) exp_q[o].push_back({k == len - 1, pbit(seed, k)});
   endtask

   task automatic drive(int p, logic [HB-1:0] h, int len, logic [31:0] seed);
      for (int k = 0; k < HB; k++) begin
         @(negedge clk);
         drv_vld[p] = 1'b1; drv_bit[p] = h[k]; drv_end[p] = 1'b0;
      end
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         drv_bit[p] = pbit(seed, k);
         drv_end[p] = (k == len - 1);
         if (k == len - 1) last_in_cyc[p] = cyc;
      end
      @(negedge clk);
      drv_vld[p] = 1'b0; drv_end[p] = 1'b0;
   endtask

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size()) != 0
             && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ov[0] && ov[2]) both_seen = 1;
         for (int o = 0; o < NP; o++) begin
            if (ov[o]) begin
               if (first_cyc[o] < 0) first_cyc[o] = cyc;
               if (exp_q[o].size() == 0) begin
                  check(0, cur_req, $sformatf("unexpected bit on output %0d", o), 1, 0);
               end else begin
                  logic [1:0] e;
                  e = exp_q[o].pop_front();
                  check({oe[o], ob[o]} == e, cur_req,
                        $sformatf("output %0d {end,bit}", o), int'({oe[o], ob[o]}), int'(e));
               end
            end else if (oe[o]) begin
               check(0, "R4", $sformatf("end without valid on output %0d", o), 1, 0);
            end
         end
      end
   end

   bit done = 0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int o = 0; o < NP; o++) begin first_cyc[o] = -1; last_in_cyc[o] = 0; end
      repeat (3) @(negedge clk);
      check(ov == '0, "R1", "outputs during reset", int'(ov), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ov == '0, "R1", "outputs after reset", int'(ov), 0);

      // R2: single differing bit, dimension 0
      cur_req = "R2";
      expect_msg(36'd4, 20, 32'h1234_5678);
      drive(LOC, 36'd4, 20, 32'h1234_5678);
      drain();
      // R2: two differing bits -> lowest dimension (0)
      expect_msg(36'd6, 15, 32'hCAFE_0001);
      drive(LOC, 36'd6, 15, 32'hCAFE_0001);
      drain();
      // R2: dimension 2 and dimension 1
      expect_msg(36'd1, 9, 32'h0F0F_3C3C);
      drive(LOC, 36'd1, 9, 32'h0F0F_3C3C);
      drain();
      expect_msg(36'd7, 33, 32'hA5A5_5A5A);
      drive(LOC, 36'd7, 33, 32'hA5A5_5A5A);
      drain();

      // R9: upper header bits all set, routing unchanged
      cur_req = "R9";
      expect_msg({33'h1_FFFF_FFFF, 3'd4}, 12, 32'h7777_1111);
      drive(LOC, {33'h1_FFFF_FFFF, 3'd4}, 12, 32'h7777_1111);
      drain();

      // R8: two messages to distinct outputs at once
      cur_req = "R8";
      expect_msg(36'h0AB_C000_1, 50, 32'h1357_9BDF);
      expect_msg(36'h0CD_E000_4, 50, 32'h2468_ACE0);
      fork
         drive(0, 36'h0AB_C000_1, 50, 32'h1357_9BDF);
         drive(2, 36'h0CD_E000_4, 50, 32'h2468_ACE0);
      join
      drain();
      check(both_seen, "R8", "outputs 0 and 2 active in same cycle", int'(both_seen), 1);

      // R5: cut-through on a long message
      cur_req = "R5";
      first_cyc[0] = -1;
      expect_msg(36'd4, 80, 32'hDEAD_BEEF);
      drive(LOC, 36'd4, 80, 32'hDEAD_BEEF);
      drain();
      check(first_cyc[0] >= 0 && first_cyc[0] < last_in_cyc[LOC], "R5",
            "first output cycle before last input cycle", first_cyc[0], last_in_cyc[LOC]);

      // R3: arrival from link 1 for this node goes to delivery (pointer -> 2)
      cur_req = "R3";
      first_cyc[LOC] = -1;
      expect_msg(36'd5, 10, 32'h0000_FFFF);
      drive(1, 36'd5, 10, 32'h0000_FFFF);
      drain();
      check(first_cyc[LOC] >= 0, "R3", "delivery port used", first_cyc[LOC], 1);

      // R7/R10: link 0 and injection contend for delivery; pointer at 2 -> injection first
      cur_req = "R7";
      expect_msg(36'h055_0000_5, 40, 32'h9999_0000);
      expect_msg(36'h0AA_0000_5, 60, 32'h3333_CCCC);
      fork
         drive(LOC, 36'h055_0000_5, 40, 32'h9999_0000);
         drive(0,   36'h0AA_0000_5, 60, 32'h3333_CCCC);
      join
      cur_req = "R10";
      drain();

      for (int o = 0; o < NP; o++)
         check(exp_q[o].size() == 0, "R4", $sformatf("bits missing on output %0d", o),
               exp_q[o].size(), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule